// File: doc/BRIEF.md
# ATA Programmed I/O Register Cycle Controller

This block runs one 16-bit programmed I/O access at a time against the register file of an ATA device. The host side offers a request with a direction, a block select (command registers or control registers), a 3-bit register offset and write data. The block turns each request into a bus cycle with three phases. In the setup phase the chip select and address are driven. In the active phase the read or write strobe is held low. In the recovery phase both strobes are high again while the chip select stays low. When the cycle ends the block returns read data together with a one-clock done pulse.

The length of each phase is set by three count inputs. The device's ready input crosses into the clock domain through a two-flop synchroniser. While the synchronised ready is low after the minimum active time, the active phase is stretched. A bounded wait counter ends a stretch that never clears and reports it as a timeout. Read data is captured in the same clock edge that raises the read strobe. Write data is driven for the whole cycle, so it is still valid when the write strobe rises.

Top module: `ata_pio_ctrl`

## Requirements
- R1: A request is taken only in a clock where `reqReady` is high. A `reqValid` pulse seen while a cycle is in progress is dropped: the address, chip selects and strobes of the running cycle do not change.
- R2: `reqCtrlBlk`=0 drives `csCmdN` low and `reqCtrlBlk`=1 drives `csCtlN` low. The other select stays high. The chosen select and `devAddr` (equal to `reqAddr`) are driven from the clock after acceptance until the end of recovery.
- R3: Setup lasts max(`cfgSetup`,1) clocks with both strobes high. The strobe that matches the direction (`rdStrbN` for `reqWrite`=0, `wrStrbN` for `reqWrite`=1) then goes low for at least max(`cfgActive`,1) clocks. The two strobes are never low together.
- R4: `devReady` passes through two flops. Once the minimum active time has run, the strobe stays low for every clock in which the synchronised ready is low.
- R5: If the synchronised ready stays low for `TIMEOUT_CLKS` clocks after the minimum active time, the strobe is released anyway. `timeoutErr` is then high together with `doneOut` for that cycle, and only then.
- R6: On a read, `rdData` takes the value on `devData` at the clock edge where `rdStrbN` rises. It holds that value until the next read completes.
- R7: On a write, the block drives `reqWdata` on `devData` from the clock after acceptance until the end of recovery, which includes the edge where `wrStrbN` rises. On reads and between cycles it leaves the bus undriven.
- R8: Recovery lasts max(`cfgRecover`,1) clocks with both strobes high and the chip select still low. `doneOut` is high for exactly one clock, the clock in which the chip select returns high.
- R9: While `rstN` is low, both strobes and both chip selects are high, and `devAddr` and `devData` are undriven. After reset the block is idle with `reqReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `reqReady` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCtrlBlk | input | 1 | 1 = control register block, 0 = command register block |
| reqAddr | input | 3 | Register offset within the block |
| reqWdata | input | 16 | Write data |
| cfgSetup | input | CNT_W | Setup clocks (0 is treated as 1) |
| cfgActive | input | CNT_W | Minimum strobe-low clocks (0 is treated as 1) |
| cfgRecover | input | CNT_W | Recovery clocks (0 is treated as 1) |
| reqReady | output | 1 | Idle, a request may be presented |
| doneOut | output | 1 | One-clock cycle completion pulse |
| timeoutErr | output | 1 | Ready wait expired, valid with `doneOut` |
| rdData | output | 16 | Captured read data |
| csCmdN | output | 1 | Command block chip select, active low |
| csCtlN | output | 1 | Control block chip select, active low |
| devAddr | output | 3 | Device register address, undriven in reset |
| rdStrbN | output | 1 | Read strobe, active low |
| wrStrbN | output | 1 | Write strobe, active low |
| devReady | input | 1 | Asynchronous device ready |
| devData | inout | 16 | Bidirectional device data bus |

## Verification
The hardest case to reach from the ports is the point where a ready wait ends. The synchroniser delay decides which clock releases the strobe, and the bench's device model changes its read data while the strobe is low. Only a capture on the exact rising edge returns the late value; an edge one clock early returns the early pattern. The stimulus holds `devReady` low across the minimum active time, raises it after a few clocks, and in another run keeps it low until the wait counter runs out. A cycle-accurate reference model follows the synchroniser and every phase counter. A stray `reqValid` pulse in the middle of a long cycle checks that the running cycle is not disturbed.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // control-to-datapath strobes, all describing the next clock
  typedef struct packed {
    logic load;     // latch request fields
    logic csOn;     // chip select asserted next clock
    logic strbOn;   // direction strobe asserted next clock
    logic capture;  // strobe is released at this edge
    logic done;     // last recovery clock
    logic toErr;    // cycle ended by ready timeout
  } ctrlStrb_t;

endpackage

// File: rtl/ata_pio_ctrl_fsm.sv
module ata_pio_ctrl_fsm
  import ata_pio_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic             rdySync,
  output logic             reqReady,
  output ctrlStrb_t        strb
);

  localparam int TO_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CLKS - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [TO_W-1:0]  toCnt;
  logic             toFlag;

  logic [CNT_W-1:0] setupLen, activeLen, recovLen;
  logic             lastSetup, minDone, release_, lastRec;

  always_comb begin
    setupLen  = (cfgSetup   == '0) ? CNT_W'(1) : cfgSetup;
    activeLen = (cfgActive  == '0) ? CNT_W'(1) : cfgActive;
    recovLen  = (cfgRecover == '0) ? CNT_W'(1) : cfgRecover;
    lastSetup = (phase == PH_SETUP)  && (cnt == setupLen - 1'b1);
    minDone   = (phase == PH_ACTIVE) && (cnt == activeLen - 1'b1);
    release_  = minDone && (rdySync || (toCnt == TO_LAST));
    lastRec   = (phase == PH_RECOV)  && (cnt == recovLen - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      toCnt  <= '0;
      toFlag <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (reqValid) begin
          phase <= PH_SETUP;
          cnt   <= '0;
        end
        PH_SETUP: if (lastSetup) begin
          phase <= PH_ACTIVE;
          cnt   <= '0;
          toCnt <= '0;
        end else cnt <= cnt + 1'b1;
        PH_ACTIVE: if (release_) begin
          phase  <= PH_RECOV;
          cnt    <= '0;
          toFlag <= !rdySync;
        end else if (minDone) toCnt <= toCnt + 1'b1;
        else cnt <= cnt + 1'b1;
        default: if (lastRec) phase <= PH_IDLE;
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end

  always_comb begin
    reqReady     = (phase == PH_IDLE);
    strb.load    = reqReady && reqValid;
    strb.csOn    = strb.load || (!reqReady && !lastRec);
    strb.strbOn  = lastSetup || ((phase == PH_ACTIVE) && !release_);
    strb.capture = release_;
    strb.done    = lastRec;
    strb.toErr   = toFlag;
  end

  AST_TO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE) |-> (toCnt < TO_W'(TIMEOUT_CLKS))); // R5

  AST_SETUP_NO_STRB: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETUP && !lastSetup) |-> !strb.strbOn); // R3

endmodule

// File: rtl/ata_pio_datapath.sv
module ata_pio_datapath
  import ata_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              reqWrite,
  input  logic              reqCtrlBlk,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  input  logic              devReady,
  output logic              rdySync,
  output logic              csCmdN,
  output logic              csCtlN,
  output logic              rdStrbN,
  output logic              wrStrbN,
  output logic [ADDR_W-1:0] addrQ,
  output logic              busOe,
  output logic [DATA_W-1:0] busWd,
  output logic [DATA_W-1:0] rdData,
  output logic              doneOut,
  output logic              timeoutErr
);

  logic syncA, syncB;
  logic selCtlQ, isWrQ;
  logic selNow, wrNow;

  assign selNow  = strb.load ? reqCtrlBlk : selCtlQ;
  assign wrNow   = strb.load ? reqWrite   : isWrQ;
  assign rdySync = syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      selCtlQ    <= 1'b0;
      isWrQ      <= 1'b0;
      addrQ      <= '0;
      busWd      <= '0;
      csCmdN     <= 1'b1;
      csCtlN     <= 1'b1;
      rdStrbN    <= 1'b1;
      wrStrbN    <= 1'b1;
      busOe      <= 1'b0;
      rdData     <= '0;
      doneOut    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      syncA <= devReady;
      syncB <= syncA;
      if (strb.load) begin
        selCtlQ <= reqCtrlBlk;
        isWrQ   <= reqWrite;
        addrQ   <= reqAddr;
        busWd   <= reqWdata;
      end
      csCmdN  <= !(strb.csOn && !selNow);
      csCtlN  <= !(strb.csOn &&  selNow);
      rdStrbN <= !(strb.strbOn && !wrNow);
      wrStrbN <= !(strb.strbOn &&  wrNow);
      busOe   <= strb.csOn && wrNow;
      if (strb.capture && !isWrQ) rdData <= busIn;
      doneOut    <= strb.done;
      timeoutErr <= strb.done && strb.toErr;
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !(!csCmdN && !csCtlN)); // R2

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdStrbN && !wrStrbN)); // R3

  AST_STRB_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrbN || !wrStrbN) |-> (!csCmdN || !csCtlN)); // R2

  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrbN |-> busOe); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> doneOut); // R5

endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqCtrlBlk,
  input  logic [2:0]       reqAddr,
  input  logic [15:0]      reqWdata,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgRecover,
  output logic             reqReady,
  output logic             doneOut,
  output logic             timeoutErr,
  output logic [15:0]      rdData,
  output logic             csCmdN,
  output logic             csCtlN,
  output wire  [2:0]       devAddr,
  output logic             rdStrbN,
  output logic             wrStrbN,
  input  logic             devReady,
  inout  wire  [15:0]      devData
);

  ctrlStrb_t   strb;
  logic        rdySync;
  logic [2:0]  addrQ;
  logic        busOe;
  logic [15:0] busWd;

  assign devAddr = rstN  ? addrQ : 3'bzzz;
  assign devData = busOe ? busWd : 16'hzzzz;

  ata_pio_ctrl_fsm #(.CNT_W(CNT_W), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgSetup(cfgSetup), .cfgActive(cfgActive), .cfgRecover(cfgRecover),
    .rdySync(rdySync), .reqReady(reqReady), .strb(strb)
  );

  ata_pio_datapath #(.DATA_W(16), .ADDR_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqCtrlBlk(reqCtrlBlk), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busIn(devData), .devReady(devReady),
    .rdySync(rdySync), .csCmdN(csCmdN), .csCtlN(csCtlN),
    .rdStrbN(rdStrbN), .wrStrbN(wrStrbN), .addrQ(addrQ),
    .busOe(busOe), .busWd(busWd), .rdData(rdData),
    .doneOut(doneOut), .timeoutErr(timeoutErr)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((!csCmdN || !csCtlN) && ($past(!csCmdN) || $past(!csCtlN)))
      |-> $stable(addrQ)); // R2

endmodule

// File: tb/ata_pio_ctrl_bench.sv
module ata_pio_ctrl_bench;

  localparam int TO_CLKS = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqCtrlBlk = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [3:0]  cfgSetup = 4'd1, cfgActive = 4'd1, cfgRecover = 4'd1;
  logic        devReady = 1'b1;
  logic        reqReady, doneOut, timeoutErr, csCmdN, csCtlN, rdStrbN, wrStrbN;
  logic [15:0] rdData;
  wire  [2:0]  devAddr;
  wire  [15:0] devData;

  logic [15:0] devVal = 16'h1234;
  int          lowCnt = 0;
  logic        devDrive;

  assign devDrive = !rdStrbN && (!csCmdN || !csCtlN);
  assign devData  = devDrive ? ((lowCnt < 2) ? 16'hDEAD : devVal) : 16'hzzzz;

  always @(posedge clk) lowCnt <= !rdStrbN ? lowCnt + 1 : 0;

  always #5 clk = ~clk;

  ata_pio_ctrl #(.CNT_W(4), .TIMEOUT_CLKS(TO_CLKS)) u_ata_pio_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCtrlBlk(reqCtrlBlk), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgSetup(cfgSetup), .cfgActive(cfgActive), .cfgRecover(cfgRecover),
    .reqReady(reqReady), .doneOut(doneOut), .timeoutErr(timeoutErr),
    .rdData(rdData), .csCmdN(csCmdN), .csCtlN(csCtlN), .devAddr(devAddr),
    .rdStrbN(rdStrbN), .wrStrbN(wrStrbN), .devReady(devReady), .devData(devData)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int          mPh = 0, mCnt = 0, mTo = 0, mAct = 0;
  bit          mS1 = 0, mS2 = 0, mDone = 0, mErr = 0, mWr = 0, mCtl = 0;
  logic [2:0]  mAddr = '0;
  logic [15:0] mWd = '0, mRd = '0;

  function automatic int lenOf(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mTo = 0; mAct = 0; mS1 = 0; mS2 = 0;
      mDone = 0; mErr = 0; mWr = 0; mCtl = 0; mAddr = '0; mWd = '0; mRd = '0;
    end else begin
      mDone = 0;
      case (mPh)
        0: if (reqValid) begin
          mPh = 1; mCnt = 0; mWr = reqWrite; mCtl = reqCtrlBlk;
          mAddr = reqAddr; mWd = reqWdata;
        end
        1: if (mCnt >= lenOf(cfgSetup) - 1) begin
          mPh = 2; mCnt = 0; mTo = 0; mAct = 0;
        end else mCnt++;
        2: begin
          if (mCnt >= lenOf(cfgActive) - 1) begin
            if (mS2 || mTo >= TO_CLKS - 1) begin
              mErr = !mS2;
              if (!mWr) mRd = (mAct + 1 >= 3) ? devVal : 16'hDEAD;
              mPh = 3; mCnt = 0;
            end else mTo++;
          end else mCnt++;
          mAct++;
        end
        default: if (mCnt >= lenOf(cfgRecover) - 1) begin
          mPh = 0; mDone = 1;
        end else mCnt++;
      endcase
      mS2 = mS1;
      mS1 = devReady;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit busy;
      busy = (mPh != 0);
      chk(reqReady == !busy, "R1 reqReady", reqReady, !busy);
      chk(csCmdN == !(busy && !mCtl), "R2 csCmdN", csCmdN, !(busy && !mCtl));
      chk(csCtlN == !(busy && mCtl), "R2 csCtlN", csCtlN, !(busy && mCtl));
      if (busy) chk(devAddr == mAddr, "R1 R2 devAddr", devAddr, mAddr);
      chk(rdStrbN == !(mPh == 2 && !mWr), "R3 R4 rdStrbN", rdStrbN, !(mPh == 2 && !mWr));
      chk(wrStrbN == !(mPh == 2 && mWr), "R3 R4 wrStrbN", wrStrbN, !(mPh == 2 && mWr));
      chk(doneOut == mDone, "R8 doneOut", doneOut, mDone);
      chk(timeoutErr == (mDone && mErr), "R5 timeoutErr", timeoutErr, mDone && mErr);
      if (busy && mWr) chk(devData == mWd, "R7 write data", devData, mWd);
      if (mDone && !mWr) chk(rdData == mRd, "R6 rdData", rdData, mRd);
    end
  end

  task automatic issue(input bit wr, input bit ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqCtrlBlk = ctl; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneOut) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(rdStrbN && wrStrbN, "R9 strobes in reset", {rdStrbN, wrStrbN}, 2'b11);
    chk(csCmdN && csCtlN, "R9 selects in reset", {csCmdN, csCtlN}, 2'b11);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && rdStrbN && wrStrbN, "R9 idle after reset",
        {reqReady, rdStrbN, wrStrbN}, 3'b111);

    // R3 R7: write to command block
    cfgSetup = 4'd2; cfgActive = 4'd3; cfgRecover = 4'd2;
    issue(1'b1, 1'b0, 3'd5, 16'hA5C3);
    // R3 R6 R8: minimum counts with zero config, early capture value
    cfgSetup = 4'd0; cfgActive = 4'd0; cfgRecover = 4'd0;
    devVal = 16'h0F0F;
    issue(1'b0, 1'b1, 3'd6, 16'h0);
    chk(rdData == 16'hDEAD, "R6 short strobe capture", rdData, 16'hDEAD);
    // R6: three-clock strobe captures late value
    cfgSetup = 4'd1; cfgActive = 4'd3; cfgRecover = 4'd1;
    devVal = 16'h1234;
    issue(1'b0, 1'b0, 3'd7, 16'h0);
    chk(rdData == 16'h1234, "R6 late capture", rdData, 16'h1234);

    // R4: ready stretch on a read
    devReady = 1'b0; devVal = 16'h55AA;
    cfgActive = 4'd1;
    fork
      issue(1'b0, 1'b0, 3'd2, 16'h0);
      begin repeat (7) @(negedge clk); devReady = 1'b1; end
    join
    chk(rdData == 16'h55AA && !timeoutErr, "R4 stretched read", rdData, 16'h55AA);

    // R4 R7: stretched write to control block
    fork
      issue(1'b1, 1'b1, 3'd3, 16'h3C3C);
      begin @(negedge clk); devReady = 1'b0; repeat (6) @(negedge clk); devReady = 1'b1; end
    join

    // R5: ready never returns
    devReady = 1'b0; devVal = 16'h7E7E;
    issue(1'b0, 1'b1, 3'd1, 16'h0);
    chk(timeoutErr == 1'b1, "R5 timeout flagged", timeoutErr, 1'b1);
    devReady = 1'b1;
    repeat (3) @(negedge clk);

    // R1: stray request during a long cycle is dropped
    cfgSetup = 4'd3; cfgActive = 4'd4; cfgRecover = 4'd3;
    fork
      issue(1'b1, 1'b0, 3'd1, 16'hBEEF);
      begin
        repeat (3) @(negedge clk);
        reqAddr = 3'd4; reqCtrlBlk = 1'b1; reqWrite = 1'b0; reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    chk(reqReady && csCmdN && csCtlN, "R1 no second cycle", {reqReady, csCmdN, csCtlN}, 3'b111);

    // R6: read data held across a write
    devVal = 16'h4242;
    cfgSetup = 4'd1; cfgActive = 4'd3; cfgRecover = 4'd1;
    issue(1'b0, 1'b0, 3'd0, 16'h0);
    issue(1'b1, 1'b0, 3'd0, 16'h9999);
    chk(rdData == 16'h4242, "R6 held over write", rdData, 16'h4242);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule